// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block is the processor-side arbiter that hands the external bus to another master on request. An external master raises a yield request. The controller lets the bus cycle already under way run to its natural end. It then raises a grant and turns off the drivers for the cycle-control outputs. A cycle that runs to its end may be a single transfer, a burst of several transfers, or a chain of locked cycles. Once the request is granted, only the external side can end the hold. When the request drops, the grant remains high for two further clocks. No new cycle-start strobe may appear in the clock in which the grant falls.

While the bus is granted away, a cycle request from the core is neither lost nor issued. It is held in a one-entry slot, and a bus-need flag is raised to the external master. After release, this stored request is the first cycle the controller starts, and it goes ahead of any request that arrives at the same moment. The controller also decides whether a snoop strobe from the external master is a valid inquiry. A strobe is accepted while the grant state is held, up to and including the clock in which the request is first seen low. A strobe one clock later is discarded.

Top module: `bus_yield_top`

## Requirements
- R1: While reset is high, and in the first clock after it, the outputs read: yieldGrant 0, drvEnable 1, cycleStart 0, busNeed 0, snoopValid 0.
- R2: When the bus is idle and yieldReq is high at a rising edge, yieldGrant is 1 and drvEnable is 0 in the clock after that edge.
- R3: A cycle in progress is never cut short. yieldGrant rises only in the clock after the edge at which lastXfer is 1 with lockCont 0. Transfers with lastXfer 0 keep the bus busy.
- R4: lastXfer 1 together with lockCont 1 continues a locked chain. cycleStart pulses in the next clock, and yieldGrant stays 0 until the chain ends.
- R5: While yieldGrant is 1, cycleStart is never 1. The grant holds for as long as yieldReq stays high.
- R6: Let the first edge at which yieldReq is sampled low while granted be edge E. yieldGrant stays 1 for the two clocks after E, falls in the third, and drvEnable returns to 1 in that same clock.
- R7: cycleStart is 0 in the clock in which yieldGrant falls. A stored request gives a cycleStart pulse in the clock after that.
- R8: A coreReq pulse sampled during the grant is stored. From the next clock, busNeed is 1 until yieldGrant falls, and the request is later issued.
- R9: At resume, the stored request goes ahead of a coreReq arriving in the same clock. That newer request is kept and is issued once the first cycle ends.
- R10: A snoopStrobe sampled at an edge in the grant state pulses snoopValid in the next clock, including at edge E. A strobe at the edge after E, or outside a grant, gives no pulse.
- R11: A coreReq arriving while a cycle is in progress is ignored. It raises no busNeed and starts no cycle later.
- R12: If yieldReq and coreReq are both sampled high on an idle bus, the grant wins. The request is stored (busNeed 1 in the clock after) and no cycleStart is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| yieldReq | input | 1 | External request for bus ownership |
| coreReq | input | 1 | One-clock pulse: core asks to start a bus cycle |
| lastXfer | input | 1 | Final transfer of the current cycle completes |
| lockCont | input | 1 | With lastXfer, another locked cycle follows |
| snoopStrobe | input | 1 | External snoop address strobe |
| yieldGrant | output | 1 | Bus ownership granted to the external master |
| drvEnable | output | 1 | Enable for address and cycle-control drivers |
| cycleStart | output | 1 | Address strobe that starts a new bus cycle |
| busNeed | output | 1 | Core is waiting on the bus during a grant |
| snoopValid | output | 1 | One-clock pulse: snoop accepted as an inquiry |

## Verification
The properties assume the following about the inputs. coreReq arrives only as a one-clock pulse. lastXfer and lockCont are asserted only while a cycle started by cycleStart is in progress. A grant can fall only three edges after a low request has been sampled. Under these assumptions the release tail and the snoop window can be checked by looking a fixed number of clocks into the past. The stimulus drives every input one clock at a time, away from the clock edge. It raises lastXfer only after a cycleStart it has itself caused, and it never holds coreReq high for two clocks in a row.

// File: rtl/bus_yield_pkg.sv
`timescale 1ns/1ps
package bus_yield_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSY,
    ST_GRANT,
    ST_REL1,
    ST_REL2,
    ST_RESUME
  } yield_state_e;

  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic issue;     // launch a cycle-start strobe
    logic setPend;   // capture a core request into the slot
    logic clrPend;   // stored request is being issued
    logic snoopHit;  // snoop strobe accepted this edge
  } yield_strobe_t;

endpackage

// File: rtl/bus_yield_ctrl.sv
`timescale 1ns/1ps
module bus_yield_ctrl
  import bus_yield_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          yieldReq,
  input  logic          coreReq,
  input  logic          lastXfer,
  input  logic          lockCont,
  input  logic          snoopStrobe,
  input  logic          pendValid,
  output logic          grantPhase,
  output yield_strobe_t strobe
);

  yield_state_e stateQ, stateNext;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    case (stateQ)
      ST_IDLE, ST_RESUME: begin
        if (yieldReq) begin
          // boundary reached: grant first, keep any new request
          stateNext      = ST_GRANT;
          strobe.setPend = coreReq;
        end else if (pendValid) begin
          stateNext      = ST_BUSY;
          strobe.issue   = 1'b1;
          strobe.clrPend = 1'b1;
          strobe.setPend = coreReq;
        end else if (coreReq) begin
          stateNext    = ST_BUSY;
          strobe.issue = 1'b1;
        end
      end
      ST_BUSY: begin
        // requests arriving here are not queued
        if (lastXfer) begin
          if (lockCont)      strobe.issue = 1'b1;
          else if (yieldReq) stateNext    = ST_GRANT;
          else               stateNext    = ST_IDLE;
        end
      end
      ST_GRANT: begin
        strobe.setPend  = coreReq;
        strobe.snoopHit = snoopStrobe;
        if (!yieldReq) stateNext = ST_REL1;
      end
      ST_REL1: begin
        strobe.setPend = coreReq;
        stateNext      = ST_REL2;
      end
      ST_REL2: begin
        strobe.setPend = coreReq;
        stateNext      = ST_RESUME;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign grantPhase = (stateQ == ST_GRANT) || (stateQ == ST_REL1) ||
                      (stateQ == ST_REL2);

endmodule

// File: rtl/bus_yield_dp.sv
`timescale 1ns/1ps
module bus_yield_dp
  import bus_yield_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  yield_strobe_t strobe,
  input  logic          grantPhase,
  output logic          pendValid,
  output logic          yieldGrant,
  output logic          drvEnable,
  output logic          cycleStart,
  output logic          busNeed,
  output logic          snoopValid
);

  logic pendQ, startQ, snoopQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ  <= 1'b0;
      startQ <= 1'b0;
      snoopQ <= 1'b0;
    end else begin
      // a fresh capture outranks the clear of the older entry
      if (strobe.setPend)      pendQ <= 1'b1;
      else if (strobe.clrPend) pendQ <= 1'b0;
      startQ <= strobe.issue;
      snoopQ <= strobe.snoopHit;
    end
  end

  assign pendValid  = pendQ;
  assign yieldGrant = grantPhase;
  assign drvEnable  = !grantPhase;
  assign cycleStart = startQ;
  assign busNeed    = grantPhase && pendQ;
  assign snoopValid = snoopQ;

endmodule

// File: rtl/bus_yield_top.sv
`timescale 1ns/1ps
module bus_yield_top
  import bus_yield_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic yieldReq,
  input  logic coreReq,
  input  logic lastXfer,
  input  logic lockCont,
  input  logic snoopStrobe,
  output logic yieldGrant,
  output logic drvEnable,
  output logic cycleStart,
  output logic busNeed,
  output logic snoopValid
);

  yield_strobe_t strobe;
  logic          grantPhase;
  logic          pendValid;

  bus_yield_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .yieldReq   (yieldReq),
    .coreReq    (coreReq),
    .lastXfer   (lastXfer),
    .lockCont   (lockCont),
    .snoopStrobe(snoopStrobe),
    .pendValid  (pendValid),
    .grantPhase (grantPhase),
    .strobe     (strobe)
  );

  bus_yield_dp dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .grantPhase(grantPhase),
    .pendValid (pendValid),
    .yieldGrant(yieldGrant),
    .drvEnable (drvEnable),
    .cycleStart(cycleStart),
    .busNeed   (busNeed),
    .snoopValid(snoopValid)
  );

endmodule

// File: rtl/bus_yield_chk.sv
`timescale 1ns/1ps
module bus_yield_chk (
  input logic clk,
  input logic rst,
  input logic yieldReq,
  input logic yieldGrant,
  input logic cycleStart,
  input logic busNeed,
  input logic snoopValid
);

  a_r5_no_start_in_grant: assert property (@(posedge clk) disable iff (rst)
    !(cycleStart && yieldGrant));

  a_r6_tail_after_low_req: assert property (@(posedge clk) disable iff (rst)
    $fell(yieldGrant) |-> !$past(yieldReq, 3));

  a_r7_quiet_on_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(yieldGrant) |-> !cycleStart);

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(yieldGrant) |-> $past(yieldReq));

  a_r8_need_only_granted: assert property (@(posedge clk) disable iff (rst)
    busNeed |-> yieldGrant);

  a_r8_need_not_lost: assert property (@(posedge clk) disable iff (rst)
    $fell(busNeed) |=> (cycleStart || yieldGrant));

  a_r10_snoop_in_grant: assert property (@(posedge clk) disable iff (rst)
    snoopValid |-> $past(yieldGrant));

endmodule

bind bus_yield_top bus_yield_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .yieldReq  (yieldReq),
  .yieldGrant(yieldGrant),
  .cycleStart(cycleStart),
  .busNeed   (busNeed),
  .snoopValid(snoopValid)
);

// File: tb/bus_yield_top_tb_top.sv
`timescale 1ns/1ps
module bus_yield_top_tb_top;

  localparam int GNT  = 0;
  localparam int DRV  = 1;
  localparam int ADS  = 2;
  localparam int NEED = 3;
  localparam int SNP  = 4;

  typedef struct {
    int    slot;
    int    sig;
    bit    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst, yieldReq, coreReq, lastXfer, lockCont, snoopStrobe;
  logic yieldGrant, drvEnable, cycleStart, busNeed, snoopValid;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sbQ[$];
  exp_t keepQ[$];
  string sigName [5] = '{"yieldGrant", "drvEnable", "cycleStart", "busNeed", "snoopValid"};

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_yield_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .yieldReq   (yieldReq),
    .coreReq    (coreReq),
    .lastXfer   (lastXfer),
    .lockCont   (lockCont),
    .snoopStrobe(snoopStrobe),
    .yieldGrant (yieldGrant),
    .drvEnable  (drvEnable),
    .cycleStart (cycleStart),
    .busNeed    (busNeed),
    .snoopValid (snoopValid)
  );

  // monitor: pops every expectation stamped with the current slot
  always @(negedge clk) begin
    logic [4:0] obs;
    obs = {snoopValid, busNeed, cycleStart, drvEnable, yieldGrant};
    keepQ = {};
    for (int i = 0; i < sbQ.size(); i++) begin
      if (sbQ[i].slot == cyc) begin
        checks++;
        if (obs[sbQ[i].sig] !== sbQ[i].val) begin
          errors++;
          $display("FAIL %s %s slot %0d actual %0b expected %0b",
                   sbQ[i].tag, sigName[sbQ[i].sig], cyc, obs[sbQ[i].sig], sbQ[i].val);
        end
      end else begin
        keepQ.push_back(sbQ[i]);
      end
    end
    sbQ = keepQ;
  end

  task automatic want(int slot, int sig, bit val, string tag);
    exp_t e;
    e.slot = slot; e.sig = sig; e.val = val; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at slot %0d actual running expected finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    rst = 1'b1; yieldReq = 1'b0; coreReq = 1'b0;
    lastXfer = 1'b0; lockCont = 1'b0; snoopStrobe = 1'b0;
    adv(3);
    // R1 reset values
    t = cyc;
    want(t, GNT, 0, "R1"); want(t, DRV, 1, "R1"); want(t, ADS, 0, "R1");
    want(t, NEED, 0, "R1"); want(t, SNP, 0, "R1");
    adv(1);
    rst = 1'b0;
    t = cyc;
    want(t + 1, GNT, 0, "R1"); want(t + 1, DRV, 1, "R1");
    adv(2);

    // grant on idle bus, request stored during grant, release tail
    t = cyc;
    yieldReq = 1'b1;
    want(t, GNT, 0, "R2");
    want(t + 1, GNT, 1, "R2"); want(t + 1, DRV, 0, "R2");
    for (int k = 1; k <= 8; k++) begin
      want(t + k, GNT, 1, "R5"); want(t + k, ADS, 0, "R5");
    end
    for (int k = 3; k <= 8; k++) want(t + k, NEED, 1, "R8");
    want(t + 2, NEED, 0, "R8");
    want(t + 9, GNT, 0, "R6"); want(t + 9, DRV, 1, "R6"); want(t + 9, NEED, 0, "R8");
    want(t + 9, ADS, 0, "R7"); want(t + 10, ADS, 1, "R7");
    want(t + 11, ADS, 0, "R8"); want(t + 12, ADS, 0, "R8");
    adv(2); coreReq = 1'b1;
    adv(1); coreReq = 1'b0;
    adv(3); yieldReq = 1'b0;
    adv(4); lastXfer = 1'b1;
    adv(1); lastXfer = 1'b0;
    adv(3);

    // burst cycle finishes before grant; request during the cycle ignored
    t = cyc;
    coreReq = 1'b1;
    want(t + 1, ADS, 1, "R3");
    for (int k = 1; k <= 3; k++) want(t + k, GNT, 0, "R3");
    want(t + 4, GNT, 1, "R3");
    want(t + 4, NEED, 0, "R11"); want(t + 5, NEED, 0, "R11");
    want(t + 9, GNT, 0, "R6");
    for (int k = 9; k <= 11; k++) want(t + k, ADS, 0, "R11");
    adv(1); coreReq = 1'b0; yieldReq = 1'b1;
    adv(1); coreReq = 1'b1;
    adv(1); coreReq = 1'b0; lastXfer = 1'b1;
    adv(1); lastXfer = 1'b0;
    adv(2); yieldReq = 1'b0;
    adv(6);

    // locked chain, then snoop window around release
    t = cyc;
    coreReq = 1'b1;
    want(t + 1, ADS, 1, "R4"); want(t + 2, ADS, 0, "R4"); want(t + 3, ADS, 1, "R4");
    for (int k = 1; k <= 4; k++) want(t + k, GNT, 0, "R4");
    want(t + 5, GNT, 1, "R4");
    want(t + 7, SNP, 1, "R10"); want(t + 8, SNP, 0, "R10");
    want(t + 9, SNP, 1, "R10"); want(t + 10, SNP, 0, "R10");
    want(t + 10, GNT, 1, "R6"); want(t + 11, GNT, 0, "R6");
    want(t + 13, SNP, 0, "R10");
    adv(1); coreReq = 1'b0; yieldReq = 1'b1;
    adv(1); lastXfer = 1'b1; lockCont = 1'b1;
    adv(1); lastXfer = 1'b0; lockCont = 1'b0;
    adv(1); lastXfer = 1'b1;
    adv(1); lastXfer = 1'b0;
    adv(1); snoopStrobe = 1'b1;
    adv(1); snoopStrobe = 1'b0;
    adv(1); snoopStrobe = 1'b1; yieldReq = 1'b0;
    adv(1);
    adv(1); snoopStrobe = 1'b0;
    adv(2); snoopStrobe = 1'b1;
    adv(1); snoopStrobe = 1'b0;
    adv(3);

    // simultaneous grant and request; stored one goes first at resume
    t = cyc;
    yieldReq = 1'b1; coreReq = 1'b1;
    want(t + 1, GNT, 1, "R12"); want(t + 1, ADS, 0, "R12"); want(t + 1, NEED, 1, "R12");
    want(t + 5, GNT, 0, "R6"); want(t + 5, ADS, 0, "R7");
    want(t + 6, ADS, 1, "R9"); want(t + 7, ADS, 0, "R9");
    want(t + 8, ADS, 1, "R9"); want(t + 9, ADS, 0, "R9");
    adv(1); coreReq = 1'b0;
    adv(1); yieldReq = 1'b0;
    adv(3); coreReq = 1'b1;
    adv(1); coreReq = 1'b0; lastXfer = 1'b1;
    adv(1); lastXfer = 1'b0;
    adv(1); lastXfer = 1'b1;
    adv(1); lastXfer = 1'b0;
    adv(4);

    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard R1 leftover actual %0d expected 0", sbQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule